// File: doc/BRIEF.md
# H-Bridge Fault Status Word Encoder

This block gathers the fault and status conditions of an H-bridge output stage into one 8-bit status word that a serial host reads back. Short-circuit events on either output are held until a clear source arrives. Over-temperature and current-limit indications are also held. Each output's short type, together with supply undervoltage and open load, is packed into a sparse 4-bit code, so any single stuck serial line always shows up as a wrong value.

The block also judges open load in two ways. While the bridge is running, it counts PWM pulses in which no freewheeling current was seen. While the bridge is off, it filters an off-state comparator result. Three groups of clear sources reset the held state: a supply event (undervoltage or sleep), a disable-then-enable cycle, and a serial reset command. A change of direction clears only the current-limit and running open-load indications.

Top module: `hbdiag_top`

## Requirements
- R1: The word is {enabled, not-overtemperature, 0, not-current-limited, code[3:0]}, MSB first; with the bridge enabled and no fault it reads 0xDF, and bit 5 is always 0.
- R2: Bit 7 follows `bridgeEn` directly. An `otEvt` pulse drives bit 6 to 0 and holds it there until a clear source.
- R3: A held short maps to code bits {~scvs2, ~scg2, ~scvs1, ~scg1}. This gives 0xE for SCG1, 0xD for SCVS1, 0xB for SCG2, 0x7 for SCVS2, 0xA, 0x9, 0x6 and 0x5 for the pairs, and 0xF for no fault. Only the values F, E, D, C, B, A, 9, 7, 6, 5 and 3 ever appear.
- R4: A short is held after its event pulse ends. Per output, the first short type held wins, and a later event of the other type on that output is ignored.
- R5: While `uvActive` is high, the code reads 0x3 at once. Undervoltage is not held, and it clears all held faults.
- R6: With the bridge enabled, OL_PULSES (5) consecutive pulses without freewheeling give code 0xC, and four such pulses do not. Five consecutive pulses with freewheeling then return the code to 0xF, and four do not.
- R7: A change of `dirIn` clears the current-limit bit and the running open-load indication.
- R8: A `sleepReq` pulse, a `spiDiagReset` pulse, or a rising edge of `bridgeEn` clears all held faults and indications in the same cycle.
- R9: While `olDisable` is high, code 0xC is never reported. The running count still proceeds, and the report appears once `olDisable` drops.
- R10: While the bridge is disabled, an off-state open-load input gives 0xC only after it has been stable for OFF_FILT_CYCLES clocks. The input is ignored while the bridge is enabled.
- R11: A held short code takes priority over the open-load code.
- R12: A `clLimit` pulse drives bit 4 to 0 until a direction change or a clear source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| bridgeEn | input | 1 | Outputs enabled (disable pin low, or software enable) |
| dirIn | input | 1 | Direction command |
| sleepReq | input | 1 | Sleep entry pulse; clears held state |
| uvActive | input | 1 | Supply undervoltage present |
| spiDiagReset | input | 1 | Serial reset-status command strobe |
| scgEvt | input | 2 | Short-to-ground event per output (bit 0 = OUT1) |
| scvsEvt | input | 2 | Short-to-supply event per output (bit 0 = OUT1) |
| otEvt | input | 1 | Over-temperature shutdown event |
| clLimit | input | 1 | Current-limit chopping event |
| pulseStrobe | input | 1 | One-cycle strobe at the end of each PWM pulse |
| freewheelSeen | input | 1 | Freewheeling seen in the pulse marked by `pulseStrobe` |
| olOffRaw | input | 1 | Off-state open-load comparator output |
| olDisable | input | 1 | Open-load reporting disabled |
| diagWord | output | 8 | Status word for serial readback |

## Verification
The bench walks every single and paired short combination and compares the code against the sparse mapping. A design that inverted a bit or swapped outputs would return a valid-looking but wrong code. It stops the open-load pulse runs at four pulses and then at five, in both directions, so an off-by-one counter shows up as an early or late 0xC. It also probes a second short type on an output that already holds one, a direction change in the middle of an open-load report, and a short that arrives while open load is shown. It samples the off-state filter both before and after its window. It checks that a disable alone does not clear held faults and that the following enable does.

// File: rtl/hbdiag_pkg.sv
package hbdiag_pkg;
  localparam int NUM_OUT = 2;

  typedef struct packed {
    logic clrAll;     // supply, sleep, serial or re-enable clear
    logic clrDir;     // direction change
    logic olSet;      // running open-load threshold reached
    logic olClr;      // running open-load release threshold reached
    logic olOffSeen;  // filtered off-state open-load level
  } diagStrobes_t;

  localparam logic [3:0] CODE_NONE = 4'hF;
  localparam logic [3:0] CODE_OL   = 4'hC;
  localparam logic [3:0] CODE_UV   = 4'h3;
endpackage

// File: rtl/hbdiag_ctrl.sv
module hbdiag_ctrl
  import hbdiag_pkg::*;
#(
  parameter int OL_PULSES       = 5,
  parameter int OFF_FILT_CYCLES = 10000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bridgeEn,
  input  logic         dirIn,
  input  logic         sleepReq,
  input  logic         uvActive,
  input  logic         spiDiagReset,
  input  logic         pulseStrobe,
  input  logic         freewheelSeen,
  input  logic         olOffRaw,
  output diagStrobes_t strobes
);
  localparam int PW = $clog2(OL_PULSES + 1);
  localparam int FW = $clog2(OFF_FILT_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(OL_PULSES - 1);
  localparam logic [FW-1:0] FILT_LAST  = FW'(OFF_FILT_CYCLES - 1);

  logic enPrev, dirPrev;
  logic clrAll, clrDir;
  logic [PW-1:0] missCnt, hitCnt;
  logic rawQ, olOffFilt;
  logic [FW-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      dirPrev <= 1'b0;
    end else begin
      enPrev  <= bridgeEn;
      dirPrev <= dirIn;
    end
  end

  always_comb begin
    clrAll = sleepReq | uvActive | spiDiagReset | (bridgeEn & ~enPrev);
    clrDir = dirIn ^ dirPrev;
  end

  // consecutive pulse counters, saturating at the threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missCnt <= '0;
      hitCnt  <= '0;
    end else if (clrAll || clrDir || !bridgeEn) begin
      missCnt <= '0;
      hitCnt  <= '0;
    end else if (pulseStrobe) begin
      if (freewheelSeen) begin
        missCnt <= '0;
        if (hitCnt != PULSE_LAST) hitCnt <= hitCnt + 1'b1;
      end else begin
        hitCnt <= '0;
        if (missCnt != PULSE_LAST) missCnt <= missCnt + 1'b1;
      end
    end
  end

  // off-state comparator stability filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ      <= 1'b0;
      stableCnt <= '0;
      olOffFilt <= 1'b0;
    end else if (bridgeEn) begin
      rawQ      <= olOffRaw;
      stableCnt <= '0;
      olOffFilt <= 1'b0;
    end else if (olOffRaw != rawQ) begin
      rawQ      <= olOffRaw;
      stableCnt <= '0;
    end else if (stableCnt == FILT_LAST) begin
      olOffFilt <= rawQ;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.clrAll    = clrAll;
    strobes.clrDir    = clrDir;
    strobes.olSet     = bridgeEn & pulseStrobe & ~freewheelSeen & (missCnt == PULSE_LAST);
    strobes.olClr     = bridgeEn & pulseStrobe & freewheelSeen & (hitCnt == PULSE_LAST);
    strobes.olOffSeen = olOffFilt;
  end

  // the filtered level only ever moves to a value the input has held
  assert_filter_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!bridgeEn && $past(!bridgeEn) && !$stable(olOffFilt)) |-> (olOffFilt == rawQ));

  assert_olset_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!bridgeEn) |-> (!strobes.olSet && !strobes.olClr));
endmodule

// File: rtl/hbdiag_datapath.sv
module hbdiag_datapath
  import hbdiag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  diagStrobes_t       strobes,
  input  logic [NUM_OUT-1:0] scgEvt,
  input  logic [NUM_OUT-1:0] scvsEvt,
  input  logic               otEvt,
  input  logic               clLimit,
  input  logic               bridgeEn,
  input  logic               uvActive,
  input  logic               olDisable,
  output logic [7:0]         diagWord
);
  logic [NUM_OUT-1:0] scgQ, scvsQ;
  logic otQ, clQ, olOnQ;
  logic olShow;
  logic [3:0] code;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        scgQ[g]  <= 1'b0;
        scvsQ[g] <= 1'b0;
      end else if (strobes.clrAll) begin
        scgQ[g]  <= 1'b0;
        scvsQ[g] <= 1'b0;
      end else if (!scgQ[g] && !scvsQ[g]) begin
        if (scgEvt[g])       scgQ[g]  <= 1'b1;
        else if (scvsEvt[g]) scvsQ[g] <= 1'b1;
      end
    end

    assert_short_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
      ((scgQ[g] || scvsQ[g]) && !strobes.clrAll) |=> ($stable(scgQ[g]) && $stable(scvsQ[g])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otQ   <= 1'b0;
      clQ   <= 1'b0;
      olOnQ <= 1'b0;
    end else begin
      if (strobes.clrAll)  otQ <= 1'b0;
      else if (otEvt)      otQ <= 1'b1;

      if (strobes.clrAll || strobes.clrDir) clQ <= 1'b0;
      else if (clLimit)                     clQ <= 1'b1;

      if (strobes.clrAll || strobes.clrDir) olOnQ <= 1'b0;
      else if (strobes.olSet)               olOnQ <= 1'b1;
      else if (strobes.olClr)               olOnQ <= 1'b0;
    end
  end

  always_comb begin
    olShow = ~olDisable & (bridgeEn ? olOnQ : strobes.olOffSeen);
    if (uvActive)                code = CODE_UV;
    else if (|{scgQ, scvsQ})     code = {~scvsQ[1], ~scgQ[1], ~scvsQ[0], ~scgQ[0]};
    else if (olShow)             code = CODE_OL;
    else                         code = CODE_NONE;
    diagWord = {bridgeEn, ~otQ, 1'b0, ~clQ, code};
  end

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAll |=> (scgQ == '0 && scvsQ == '0 && !otQ && !clQ && !olOnQ));

  assert_dir_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrDir |=> (!clQ && !olOnQ));

  assert_code_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    diagWord[3:0] inside {4'hF, 4'hE, 4'hD, 4'hC, 4'hB, 4'hA, 4'h9, 4'h7, 4'h6, 4'h5, 4'h3});

  assert_ol_suppressed_R9: assert property (@(posedge clk) disable iff (!rstN)
    olDisable |-> (diagWord[3:0] != CODE_OL));

  assert_tv_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !diagWord[5]);
endmodule

// File: rtl/hbdiag_top.sv
module hbdiag_top
  import hbdiag_pkg::*;
#(
  parameter int OL_PULSES       = 5,
  parameter int OFF_FILT_CYCLES = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bridgeEn,
  input  logic       dirIn,
  input  logic       sleepReq,
  input  logic       uvActive,
  input  logic       spiDiagReset,
  input  logic [1:0] scgEvt,
  input  logic [1:0] scvsEvt,
  input  logic       otEvt,
  input  logic       clLimit,
  input  logic       pulseStrobe,
  input  logic       freewheelSeen,
  input  logic       olOffRaw,
  input  logic       olDisable,
  output logic [7:0] diagWord
);
  diagStrobes_t strobes;

  hbdiag_ctrl #(
    .OL_PULSES(OL_PULSES),
    .OFF_FILT_CYCLES(OFF_FILT_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bridgeEn(bridgeEn), .dirIn(dirIn),
    .sleepReq(sleepReq), .uvActive(uvActive), .spiDiagReset(spiDiagReset),
    .pulseStrobe(pulseStrobe), .freewheelSeen(freewheelSeen),
    .olOffRaw(olOffRaw), .strobes(strobes)
  );

  hbdiag_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .scgEvt(scgEvt),
    .scvsEvt(scvsEvt), .otEvt(otEvt), .clLimit(clLimit),
    .bridgeEn(bridgeEn), .uvActive(uvActive), .olDisable(olDisable),
    .diagWord(diagWord)
  );
endmodule

// File: tb/hbdiag_top_bench.sv
`timescale 1ns/1ps
module hbdiag_top_bench;
  localparam int FILT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bridgeEn = 1'b1, dirIn = 1'b0, sleepReq = 1'b0, uvActive = 1'b0;
  logic spiDiagReset = 1'b0, otEvt = 1'b0, clLimit = 1'b0;
  logic pulseStrobe = 1'b0, freewheelSeen = 1'b0, olOffRaw = 1'b0, olDisable = 1'b0;
  logic [1:0] scgEvt = 2'b00, scvsEvt = 2'b00;
  logic [7:0] diagWord;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  hbdiag_top #(.OL_PULSES(5), .OFF_FILT_CYCLES(FILT)) u_hbdiag_top (
    .clk(clk), .rstN(rstN), .bridgeEn(bridgeEn), .dirIn(dirIn),
    .sleepReq(sleepReq), .uvActive(uvActive), .spiDiagReset(spiDiagReset),
    .scgEvt(scgEvt), .scvsEvt(scvsEvt), .otEvt(otEvt), .clLimit(clLimit),
    .pulseStrobe(pulseStrobe), .freewheelSeen(freewheelSeen),
    .olOffRaw(olOffRaw), .olDisable(olDisable), .diagWord(diagWord)
  );

  // {scgEvt, scvsEvt, expected code}
  localparam logic [7:0] VEC [9] = '{
    {2'b01, 2'b00, 4'hE}, {2'b00, 2'b01, 4'hD}, {2'b10, 2'b00, 4'hB},
    {2'b00, 2'b10, 4'h7}, {2'b11, 2'b00, 4'hA}, {2'b10, 2'b01, 4'h9},
    {2'b01, 2'b10, 4'h6}, {2'b00, 2'b11, 4'h5}, {2'b00, 2'b00, 4'hF}
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (diagWord !== exp) begin
      fails++;
      $display("FAIL %s: diagWord=%h expected=%h", req, diagWord, exp);
    end
  endtask

  task automatic pulse(input logic fw, input int n);
    for (int i = 0; i < n; i++) begin
      pulseStrobe = 1'b1; freewheelSeen = fw;
      tick();
      pulseStrobe = 1'b0; freewheelSeen = 1'b0;
      tick();
    end
  endtask

  task automatic serialClear();
    spiDiagReset = 1'b1; tick(); spiDiagReset = 1'b0; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 reset word", 8'hDF);
    rstN = 1'b1;
    tick(2);
    check("R1 idle word", 8'hDF);

    // R3 code table walk
    foreach (VEC[k]) begin
      serialClear();
      scgEvt = VEC[k][7:6]; scvsEvt = VEC[k][5:4];
      tick();
      scgEvt = 2'b00; scvsEvt = 2'b00;
      tick();
      check($sformatf("R3 vector %0d", k), {4'b1101, VEC[k][3:0]});
    end

    // R4 first type per output wins, held after event
    serialClear();
    scgEvt = 2'b01; tick(); scgEvt = 2'b00;
    scvsEvt = 2'b01; tick(); scvsEvt = 2'b00; tick(3);
    check("R4 held first type", 8'hDE);

    // R8 serial clear
    serialClear();
    check("R8 serial clear", 8'hDF);

    // R8 disable alone keeps, enable clears; R2 EN bit
    scgEvt = 2'b10; tick(); scgEvt = 2'b00;
    bridgeEn = 1'b0; tick();
    check("R2 EN low keeps short", 8'h5B);
    bridgeEn = 1'b1; tick();
    check("R8 re-enable clears", 8'hDF);

    // R8 sleep clear
    scvsEvt = 2'b10; tick(); scvsEvt = 2'b00; tick();
    sleepReq = 1'b1; tick(); sleepReq = 1'b0; tick();
    check("R8 sleep clears", 8'hDF);

    // R5 undervoltage
    scgEvt = 2'b01; tick(); scgEvt = 2'b00; tick();
    uvActive = 1'b1; #1;
    check("R5 uv code", 8'hD3);
    tick(2);
    uvActive = 1'b0; tick();
    check("R5 uv released, short gone", 8'hDF);

    // R2 overtemperature
    otEvt = 1'b1; tick(); otEvt = 1'b0; tick(2);
    check("R2 ot held", 8'h9F);
    serialClear();

    // R12 current limit and R7 direction
    clLimit = 1'b1; tick(); clLimit = 1'b0; tick(2);
    check("R12 cl held", 8'hCF);
    dirIn = 1'b1; tick(2);
    check("R7 dir clears cl", 8'hDF);

    // R6 running open load thresholds
    pulse(1'b0, 4);
    check("R6 four misses", 8'hDF);
    pulse(1'b0, 1);
    check("R6 fifth miss", 8'hDC);
    pulse(1'b1, 4);
    check("R6 four hits keep", 8'hDC);
    pulse(1'b1, 1);
    check("R6 fifth hit clears", 8'hDF);

    // R7 direction clears open load
    pulse(1'b0, 5);
    dirIn = 1'b0; tick();
    check("R7 dir clears ol", 8'hDF);

    // R9 suppression
    olDisable = 1'b1;
    pulse(1'b0, 5);
    check("R9 suppressed", 8'hDF);
    olDisable = 1'b0; #1;
    check("R9 released", 8'hDC);

    // R11 short over open load
    scgEvt = 2'b01; tick(); scgEvt = 2'b00; tick();
    check("R11 short wins", 8'hDE);
    serialClear();

    // R10 off-state filter
    olOffRaw = 1'b1; tick(4);
    check("R10 ignored while enabled", 8'hDF);
    bridgeEn = 1'b0; tick(FILT / 2);
    check("R10 inside filter", 8'h5F);
    tick(FILT + 4);
    check("R10 after filter", 8'h5C);
    olDisable = 1'b1; #1;
    check("R9 off-state suppressed", 8'h5F);
    olDisable = 1'b0; olOffRaw = 1'b0; tick(2 * FILT + 4);
    check("R10 released", 8'h5F);
    bridgeEn = 1'b1; tick();
    check("R1 back to idle", 8'hDF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule